// File: doc/BRIEF.md
# DRAM Write-Enable Refresh Guard

This block sits between the processor read/write line and the write-enable pins of a DRAM bank. It samples the active-low row and column strobes on a clock that runs several times faster than the strobes change. From those samples it recognises a column-before-row refresh cycle and, for the whole of that cycle, holds the DRAM write-enable at its inactive high level. High-density DRAM treats a low write-enable during such a refresh as a request to enter a test mode, and that test mode destroys stored data. The processor can legitimately be writing to an I/O or expansion-bus address while a refresh begins, so the read/write line may be low at exactly the wrong moment.

Outside refresh the gated write-enable follows the processor line. The hold starts as soon as the column strobe is seen low while the row strobe is still high, which is the column-first condition. This way write-enable is already high on the sample where the row strobe falls. A refresh-active output is high for exactly the span of the hold. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `refresh_we_guard`

## Requirements
- R1: While rst_ni is low, we_no is 1 and rfsh_active_o is 0, whatever the strobes and rw_i are doing.
- R2: With no hold in progress, we_no equals the rw_i value sampled at the previous rising edge (1 = read, 0 = write).
- R3: A refresh is detected when ras_ni is sampled 0, having been 1 on the previous sample, while cas_ni was 0 on the previous sample. From the next edge on, we_no is 1 and rfsh_active_o is 1, even when rw_i is 0.
- R4: A normal access, in which ras_ni falls while cas_ni was 1 on the previous sample (including both strobes falling on the same sample), is not a refresh. we_no keeps following rw_i and rfsh_active_o stays 0.
- R5: A sample with cas_ni = 0 and ras_ni = 1 starts the hold at the next edge, before ras_ni falls. we_no is 1 and rfsh_active_o is 1.
- R6: Once a refresh is in progress, the hold continues until a sample shows both ras_ni and cas_ni at 1. A single strobe returning high does not end it. On the releasing edge, we_no takes the sampled rw_i.
- R7: If the column strobe returns high without the row strobe having fallen, the hold ends at that sample and we_no follows rw_i again.
- R8: rfsh_active_o is 1 exactly while the hold is in force, and we_no is never 0 while rfsh_active_o is 1.
- R9: A hidden refresh is guarded. In that sequence the row strobe rises at the end of a normal access while the column strobe stays low, and then the row strobe falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, much faster than strobe edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_ni | input | 1 | Row address strobe, active low |
| cas_ni | input | 1 | Column address strobe, active low |
| rw_i | input | 1 | Processor read/write, 1 = read, 0 = write |
| we_no | output | 1 | Gated DRAM write-enable, active low |
| rfsh_active_o | output | 1 | High while write-enable is held inactive |

## Verification
The dangerous case needs a particular ordering across samples. The processor line must be low while the column strobe leads the row strobe, and the strobes must then release one at a time, in either order. The stimulus table drives exactly those orderings with rw_i held at 0. It also covers a hidden refresh that follows a normal access, and a column pulse that ends without any row strobe. Directed steps then assert reset in the middle of a refresh.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RFSH  = 2'd2
  } rwg_state_e;
endpackage

// File: rtl/rwg_strobe_edge.sv
module rwg_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  output logic ras_fall_o,
  output logic cbr_start_o,
  output logic cas_first_o,
  output logic both_high_o
);
  logic ras_q, cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
    end
  end

  always_comb begin
    ras_fall_o  = ras_q && !ras_ni;
    cbr_start_o = ras_fall_o && !cas_q;  // column already low on prior sample
    cas_first_o = !cas_ni && ras_ni;
    both_high_o = ras_ni && cas_ni;
  end
endmodule

// File: rtl/rwg_ctrl.sv
module rwg_ctrl
  import rwg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_fall_i,
  input  logic cbr_start_i,
  input  logic cas_first_i,
  input  logic both_high_i,
  output logic hold_next_o
);
  rwg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cbr_start_i)      state_d = ST_RFSH;
        else if (cas_first_i) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (cbr_start_i)      state_d = ST_RFSH;
        else if (both_high_i) state_d = ST_IDLE;
      end
      ST_RFSH: begin
        if (both_high_i)      state_d = ST_IDLE;
      end
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign hold_next_o = (state_d != ST_IDLE);

  // R3
  cbr_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_start_i |=> state_q == ST_RFSH);

  // R4
  normal_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ras_fall_i && !cbr_start_i) |=> state_q == ST_IDLE);

  // R6
  rfsh_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RFSH && !both_high_i) |=> state_q == ST_RFSH);

  // R7
  cas_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && both_high_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/rwg_we_stage.sv
module rwg_we_stage #(
  parameter logic WE_IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_next_i,
  input  logic rw_i,
  output logic we_no,
  output logic active_o
);
  logic we_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= WE_IDLE;
      act_q <= 1'b0;
    end else begin
      we_q  <= hold_next_i ? WE_IDLE : rw_i;
      act_q <= hold_next_i;
    end
  end

  assign we_no    = we_q;
  assign active_o = act_q;

  // R2
  pass_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_next_i |=> we_no == $past(rw_i));

  // R8
  we_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> we_no);
endmodule

// File: rtl/refresh_we_guard.sv
module refresh_we_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic rw_i,
  output logic we_no,
  output logic rfsh_active_o
);
  logic ras_fall, cbr_start, cas_first, both_high, hold_next;

  rwg_strobe_edge i_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ras_ni      (ras_ni),
    .cas_ni      (cas_ni),
    .ras_fall_o  (ras_fall),
    .cbr_start_o (cbr_start),
    .cas_first_o (cas_first),
    .both_high_o (both_high)
  );

  rwg_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ras_fall_i  (ras_fall),
    .cbr_start_i (cbr_start),
    .cas_first_i (cas_first),
    .both_high_i (both_high),
    .hold_next_o (hold_next)
  );

  rwg_we_stage #(.WE_IDLE(1'b1)) i_we (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_next_i (hold_next),
    .rw_i        (rw_i),
    .we_no       (we_no),
    .active_o    (rfsh_active_o)
  );

  // R5
  early_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_ni && ras_ni) |=> (rfsh_active_o && we_no));

  // R9
  hidden_rfsh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_active_o && !cas_ni && $fell(ras_ni)) |=> rfsh_active_o);
endmodule

// File: tb/test_refresh_we_guard.sv
`timescale 1ns/1ps
module test_refresh_we_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, rw = 1'b0;
  logic we_n, act;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refresh_we_guard i_refresh_we_guard (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .rw_i(rw), .we_no(we_n), .rfsh_active_o(act)
  );

  // {ras_n, cas_n, rw, exp_we_n, exp_active}
  localparam logic [4:0] VEC [0:24] = '{
    5'b11110, 5'b11000, 5'b01000, 5'b00000, 5'b00110,
    5'b11110, 5'b10011, 5'b00011, 5'b00011, 5'b01011,
    5'b10011, 5'b11000, 5'b10111, 5'b11000, 5'b10011,
    5'b00011, 5'b11110, 5'b11000, 5'b01000, 5'b00000,
    5'b10011, 5'b00011, 5'b11110, 5'b00000, 5'b11000
  };

  function automatic string req_of(int idx);
    case (idx)
      0, 1, 5, 16, 17, 22: return "R2";
      2, 3, 4, 18, 19, 23, 24: return "R4";
      6, 12, 14: return "R5";
      7, 8, 15: return "R3";
      9, 10, 11: return "R6";
      13: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic exp_we, logic exp_act);
    n_chk++;
    if (we_n !== exp_we || act !== exp_act) begin
      n_bad++;
      $display("FAIL %s: we_n=%b act=%b expected we_n=%b act=%b at %0t",
               req, we_n, act, exp_we, exp_act, $time);
    end
    // R8: write-enable never low while hold flagged
    n_chk++;
    if (act === 1'b1 && we_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R8: we_n=%b while active, expected 1", we_n);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state with processor writing
    #9;
    check("R1", 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 25; i++) begin
      ras_n = VEC[i][4]; cas_n = VEC[i][3]; rw = VEC[i][2];
      @(posedge clk);
      @(negedge clk);
      check(req_of(i), VEC[i][1], VEC[i][0]);
    end
    // Directed: enter refresh with write pending, then reset mid-refresh (R1)
    ras_n = 1'b1; cas_n = 1'b0; rw = 1'b0;
    @(posedge clk); @(negedge clk);
    ras_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3", 1'b1, 1'b1);
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R1", 1'b1, 1'b0);
    ras_n = 1'b1; cas_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2", 1'b0, 1'b0);
    // Long refresh: release order cas first then ras (R6)
    cas_n = 1'b0;
    @(posedge clk); @(negedge clk);
    ras_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); @(negedge clk);
      check("R3", 1'b1, 1'b1);
    end
    cas_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6", 1'b1, 1'b1);
    ras_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6", 1'b0, 1'b0);
    finish_run();
  end
endmodule